// File: doc/BRIEF.md
# Page Write Collector with Commit Timer

This block sits behind a two-wire serial slave engine in a byte-wide non-volatile memory. The engine loads a starting word address and then hands over the data bytes it receives one at a time. Each byte is placed in a 32-slot page buffer. The slot is chosen by the low five bits of a shared address counter. Only those five bits advance, and they wrap, so the page number never changes during one transfer. If more than 32 bytes arrive, later bytes overwrite earlier ones in the same slots.

When the bus STOP arrives, every slot that received a byte is written to the array in one wide write cycle, using a per-byte mask. Slots that received nothing keep their stored contents. The block then reports busy for a write-cycle time given in system clocks, and it ignores every request until that time has passed. A repeated START before STOP throws the collected page away. A protect pin blocks any commit that targets the upper half of the array.

Top module: `page_commit_buf`

## Requirements
- R1: `addr_ld_i` loads `addr_i` into the address counter and empties the page buffer. Slot j (0 to 31) holds the byte for low address bits equal to j, and `mem_mask_o` bit j marks that slot.
- R2: Each accepted `byte_vld_i` stores `byte_i` in the slot given by the counter's low five bits. Those bits then advance by one modulo 32, and the upper counter bits stay unchanged.
- R3: When more than 32 bytes arrive before STOP, the slot keeps the last byte written to it.
- R4: A `stop_i` with at least one buffered byte raises `mem_we_o` for exactly one cycle, in the cycle after `stop_i` is sampled. On that cycle the outputs are as follows:
  - `mem_mask_o` bit j is set exactly when slot j received a byte.
  - `mem_data_o[8j+7:8j]` carries slot j.
  - `mem_page_o` carries the counter's upper bits.
- R5: A `stop_i` with an empty buffer produces no write and no busy.
- R6: After a commit, `busy_o` is high for exactly WR_CYCLES cycles, starting with the write cycle. While `busy_o` is high, all inputs are ignored.
- R7: If `wp_i` is high when `stop_i` is sampled and the page's top address bit is 1, no write occurs, `busy_o` stays low and the buffer is emptied. With `wp_i` low, or for a lower-half page, the commit proceeds.
- R8: `restart_i` empties the buffer without programming, so a following `stop_i` writes nothing.
- R9: After any `stop_i`, `cur_addr_o` holds the start page with offset (start + bytes received) mod 32, which is the last written address plus one, wrapped within the page.
- R10: After reset, `busy_o` and `mem_we_o` are 0, `cur_addr_o` is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_ld_i | input | 1 | Load start word address |
| addr_i | input | ADDR_W | Start word address |
| byte_vld_i | input | 1 | Received data byte strobe |
| byte_i | input | DATA_W | Received data byte |
| restart_i | input | 1 | Repeated START seen; drop buffered page |
| stop_i | input | 1 | STOP seen; commit buffered page |
| wp_i | input | 1 | Protect upper half of array |
| mem_we_o | output | 1 | One-cycle array page write strobe |
| mem_page_o | output | ADDR_W-OFS_W | Page number being written |
| mem_mask_o | output | 2**OFS_W | Per-byte write enable within page |
| mem_data_o | output | (2**OFS_W)*DATA_W | Page data, slot j at bits [DATA_W*j +: DATA_W] |
| busy_o | output | 1 | Write cycle in progress |
| cur_addr_o | output | ADDR_W | Shared word address counter |

## Verification
The assertions assume that the engine raises at most one of the load, byte, restart and stop strobes in any cycle. They also assume that `wp_i` is steady around a STOP. The stimulus meets both assumptions: it drives each strobe on its own, for one cycle, from the falling clock edge, and it changes `wp_i` only before a transfer begins. The sweep covers every page of a small array. For each page it uses start offsets at the start, middle and end of the page, byte counts below, at and beyond the page size, and both protect levels. The expected masks and slot contents come from modular arithmetic on the start offset and the byte index.

// File: rtl/page_commit_buf.sv
module page_commit_buf #(
  parameter int ADDR_W    = 13,
  parameter int OFS_W     = 5,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 1250000,
  localparam int PAGE     = 2 ** OFS_W,
  localparam int PG_W     = ADDR_W - OFS_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   addr_ld_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic                   byte_vld_i,
  input  logic [DATA_W-1:0]      byte_i,
  input  logic                   restart_i,
  input  logic                   stop_i,
  input  logic                   wp_i,
  output logic                   mem_we_o,
  output logic [PG_W-1:0]        mem_page_o,
  output logic [PAGE-1:0]        mem_mask_o,
  output logic [PAGE*DATA_W-1:0] mem_data_o,
  output logic                   busy_o,
  output logic [ADDR_W-1:0]      cur_addr_o
);
  localparam int CNT_W = $clog2(WR_CYCLES > 1 ? WR_CYCLES : 2);

  logic [DATA_W-1:0] slot_q [PAGE];
  logic [PAGE-1:0]   vld_q, mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PG_W-1:0]   page_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q, we_q;

  wire [OFS_W-1:0] ofs     = addr_q[OFS_W-1:0];
  wire             protect = wp_i & addr_q[ADDR_W-1];
  wire             take    = !busy_q && !addr_ld_i && !restart_i && byte_vld_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      mask_q <= '0;
      addr_q <= '0;
      page_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end else if (addr_ld_i) begin
        addr_q <= addr_i;
        vld_q  <= '0;
      end else if (restart_i) begin
        vld_q <= '0;
      end else if (byte_vld_i) begin
        vld_q[ofs]            <= 1'b1;
        addr_q[OFS_W-1:0]     <= ofs + 1'b1;
      end else if (stop_i) begin
        vld_q <= '0;
        if (|vld_q && !protect) begin
          we_q   <= 1'b1;
          mask_q <= vld_q;
          page_q <= addr_q[ADDR_W-1:OFS_W];
          busy_q <= 1'b1;
          cnt_q  <= CNT_W'(WR_CYCLES - 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) slot_q[ofs] <= byte_i;
  end

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    assign mem_data_o[g*DATA_W +: DATA_W] = slot_q[g];
  end

  assign mem_we_o   = we_q;
  assign mem_page_o = page_q;
  assign mem_mask_o = mask_q;
  assign busy_o     = busy_q;
  assign cur_addr_o = addr_q;

  assert_we_after_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(stop_i));
  assert_we_has_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_mask_o != '0) && busy_o);
  assert_protect_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !($past(wp_i) && mem_page_o[PG_W-1]));
  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(cur_addr_o));
  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_i && !busy_o && !addr_ld_i && !restart_i)
      |=> cur_addr_o[ADDR_W-1:OFS_W] == $past(cur_addr_o[ADDR_W-1:OFS_W]));
endmodule

// File: tb/page_commit_buf_tb.sv
module page_commit_buf_tb;
  localparam int AW = 7, OW = 5, DW = 8, WR = 20, PG = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic addr_ld = 0, byte_vld = 0, restart = 0, stop = 0, wp = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] bval = '0;
  logic mem_we, busy;
  logic [AW-OW-1:0] mem_page;
  logic [PG-1:0] mem_mask;
  logic [PG*DW-1:0] mem_data;
  logic [AW-1:0] cur_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [PG-1:0] exp_mask;
  logic [DW-1:0] exp_data [PG];

  always #2 clk = ~clk;

  page_commit_buf #(.ADDR_W(AW), .OFS_W(OW), .DATA_W(DW), .WR_CYCLES(WR)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_ld_i(addr_ld), .addr_i(addr), .byte_vld_i(byte_vld),
    .byte_i(bval), .restart_i(restart), .stop_i(stop), .wp_i(wp), .mem_we_o(mem_we),
    .mem_page_o(mem_page), .mem_mask_o(mem_mask), .mem_data_o(mem_data),
    .busy_o(busy), .cur_addr_o(cur_addr));

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    addr_ld = 1; addr = a; @(negedge clk); addr_ld = 0;
  endtask
  task automatic do_byte(input logic [DW-1:0] b);
    byte_vld = 1; bval = b; @(negedge clk); byte_vld = 0;
  endtask
  task automatic do_restart();
    restart = 1; @(negedge clk); restart = 0;
  endtask
  task automatic do_stop();
    stop = 1; @(negedge clk); stop = 0;
  endtask

  task automatic check_commit(input int page);
    int cyc;
    chk("R4 write strobe", mem_we, 1);
    chk("R1 mask", mem_mask, exp_mask);
    chk("R2 page", mem_page, page);
    for (int j = 0; j < PG; j++)
      if (exp_mask[j]) chk("R3 slot data", mem_data[j*DW +: DW], exp_data[j]);
    cyc = 0;
    while (busy && cyc < 1000) begin
      cyc++;
      @(negedge clk);
      if (cyc == 1) chk("R4 single write cycle", mem_we, 0);
    end
    chk("R6 busy length", cyc, WR);
  endtask

  task automatic check_none(input string req);
    chk(req, mem_we, 0);
    chk(req, busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int starts [3] = '{0, 13, 31};
    int counts [5] = '{1, 5, 32, 33, 40};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 busy after reset", busy, 0);
    chk("R10 we after reset", mem_we, 0);
    chk("R10 addr after reset", cur_addr, 0);
    do_stop();
    check_none("R10 empty buffer after reset");

    for (int p = 0; p < 4; p++)
      for (int si = 0; si < 3; si++)
        for (int ni = 0; ni < 5; ni++)
          for (int w = 0; w < 2; w++) begin
            int s, n;
            logic [DW-1:0] b;
            s = starts[si]; n = counts[ni];
            wp = w[0];
            do_load(AW'(p*PG + s));
            exp_mask = '0;
            for (int k = 0; k < n; k++) begin
              b = DW'(p*37 + s*5 + k*11 + 1);
              exp_mask[(s+k)%PG] = 1'b1;
              exp_data[(s+k)%PG] = b;
              do_byte(b);
            end
            do_stop();
            if (w == 1 && p >= 2) check_none("R7 protected upper half");
            else check_commit(p);
            chk("R9 address after commit", cur_addr, p*PG + (s+n)%PG);
            wp = 0;
          end

    // R8: repeated START drops buffered bytes
    do_load(7'd40);
    do_byte(8'hA5); do_byte(8'h5A); do_byte(8'h33);
    do_restart();
    do_stop();
    check_none("R8 abandoned page");

    // R5: stop with nothing buffered
    do_load(7'd3);
    do_stop();
    check_none("R5 empty stop");

    // R6: requests during busy are ignored
    do_load(7'd70);
    do_byte(8'h11);
    exp_mask = 32'h0000_0040; exp_data[6] = 8'h11;
    stop = 1; @(negedge clk); stop = 0;
    chk("R4 write strobe", mem_we, 1);
    do_load(7'd5); do_byte(8'h99); do_byte(8'h98); do_stop();
    while (busy) @(negedge clk);
    chk("R6 address untouched while busy", cur_addr, 71);
    do_stop();
    check_none("R6 bytes during busy dropped");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule